// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical memory address. It does this by adding the offset to a segment base. The block holds four 16-bit segment registers: code, data, stack and extra. Each base is the register value shifted left by four bits. A segment therefore covers 64 KB. Bases only need to differ by 16 bytes, so two segments can overlap.

For each request, the caller states what kind of access it is: an ordinary data access, a string destination, a stack access or an instruction fetch. The block picks the segment from that access kind. The caller may supply a valid override to name a different segment for any access except a string destination. String destinations always use the extra segment.

The offset comes from one of two places:
- In direct mode, it is the offset field carried in the instruction.
- Otherwise, it is an effective address computed outside the block.

The result is registered and marked with a valid strobe one clock after the request.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset, `pa_valid` is 0, `pa` is 0, and all four segment registers read as 0. A request made straight after reset therefore returns the offset alone.
- R2: The cycle after a request is taken (`req_valid`=1 at a rising edge), `pa` equals (segment << 4) + offset. Only the low 20 bits are kept.
- R3: Segment indices are fixed as 0 = code, 1 = data, 2 = stack, 3 = extra. Access kind 0 (data) with no override uses the data segment.
- R4: Access kind 1 (string destination) always uses the extra segment, even when `ovr_valid` is 1.
- R5: Access kind 3 (fetch) uses the code segment and access kind 2 (stack) uses the stack segment when no override is given.
- R6: For access kinds 0, 2 and 3, `ovr_valid`=1 makes the block use the segment named by `ovr_sel` instead of the default.
- R7: With `direct`=1 the offset is `disp_ofs`. With `direct`=0 it is `ind_ofs`.
- R8: A segment write (`seg_we`, `seg_wsel`, `seg_wdata`) affects requests from the next clock onward. A request taken in the same cycle as the write still uses the old value.
- R9: `pa_valid` follows `req_valid` with one cycle of delay. While no request is taken, `pa` and `pa_seg` keep their last values.
- R10: The sum wraps at 1 MB. For example, segment 0xFFFF with offset 0xFFFF gives 0x0FFEF.
- R11: `pa_seg` reports the index of the segment used for the address shown on `pa`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seg_we | input | 1 | Segment register write enable |
| seg_wsel | input | 2 | Segment register to write (0 code, 1 data, 2 stack, 3 extra) |
| seg_wdata | input | 16 | New segment value |
| req_valid | input | 1 | Address request |
| req_kind | input | 2 | Access kind: 0 data, 1 string destination, 2 stack, 3 fetch |
| ovr_valid | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment index |
| direct | input | 1 | 1: offset from instruction field, 0: external effective address |
| disp_ofs | input | 16 | Offset field of the instruction |
| ind_ofs | input | 16 | Externally computed effective address |
| pa_valid | output | 1 | Physical address valid strobe |
| pa | output | 20 | Physical address |
| pa_seg | output | 2 | Segment index used for `pa` |

## Verification
The in-module assertions check the following on every cycle:
- the strobe timing and the holding of `pa` and `pa_seg` while idle;
- the forced extra segment for string destinations;
- the override and default segment choices reported on `pa_seg`.

Only the bench can show the rest, because it depends on a model of register contents over time:
- the arithmetic value of `pa`, including the wrap at 1 MB;
- the choice between the two offset sources;
- the reset contents of the segment registers;
- the one-cycle latency of a segment write when a request shares its cycle.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int OFS_W = 16,
  parameter int SEG_W = 16,
  parameter int SHIFT = 4,
  parameter int PA_W  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_we,
  input  logic [1:0]       seg_wsel,
  input  logic [SEG_W-1:0] seg_wdata,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic             ovr_valid,
  input  logic [1:0]       ovr_sel,
  input  logic             direct,
  input  logic [OFS_W-1:0] disp_ofs,
  input  logic [OFS_W-1:0] ind_ofs,
  output logic             pa_valid,
  output logic [PA_W-1:0]  pa,
  output logic [1:0]       pa_seg
);
  localparam int BASE_W = SEG_W + SHIFT;
  localparam int SUM_W  = ((BASE_W > OFS_W) ? BASE_W : OFS_W) + 1;

  localparam logic [1:0] SEG_CODE  = 2'd0;
  localparam logic [1:0] SEG_DATA  = 2'd1;
  localparam logic [1:0] SEG_STACK = 2'd2;
  localparam logic [1:0] SEG_EXTRA = 2'd3;

  localparam logic [1:0] K_DATA  = 2'd0;
  localparam logic [1:0] K_STR   = 2'd1;
  localparam logic [1:0] K_STACK = 2'd2;
  localparam logic [1:0] K_FETCH = 2'd3;

  logic [SEG_W-1:0] seg_q [4];
  logic [1:0]       sel;
  logic [OFS_W-1:0] ea;
  logic [SUM_W-1:0] sum;

  for (genvar i = 0; i < 4; i++) begin : g_seg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                           seg_q[i] <= '0;
      else if (seg_we && seg_wsel == 2'(i)) seg_q[i] <= seg_wdata;
  end

  always_comb begin
    case (req_kind)
      K_FETCH: sel = SEG_CODE;
      K_STACK: sel = SEG_STACK;
      K_STR:   sel = SEG_EXTRA;
      default: sel = SEG_DATA;
    endcase
    if (ovr_valid && req_kind != K_STR) sel = ovr_sel;
  end

  assign ea  = direct ? disp_ofs : ind_ofs;
  assign sum = (SUM_W'(seg_q[sel]) << SHIFT) + SUM_W'(ea);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pa_valid <= 1'b0;
      pa       <= '0;
      pa_seg   <= '0;
    end else begin
      pa_valid <= req_valid;
      if (req_valid) begin
        pa     <= sum[PA_W-1:0];
        pa_seg <= sel;
      end
    end

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> pa_valid);
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!pa_valid && $stable(pa) && $stable(pa_seg)));
  a_r4_string_extra: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == K_STR) |=> pa_seg == SEG_EXTRA);
  a_r6_override: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ovr_valid && req_kind != K_STR) |=> pa_seg == $past(ovr_sel));
  a_r3_data_default: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ovr_valid && req_kind == K_DATA) |=> pa_seg == SEG_DATA);
  a_r5_fetch_code: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ovr_valid && req_kind == K_FETCH) |=> pa_seg == SEG_CODE);
endmodule

// File: tb/seg_addr_gen_test.sv
`timescale 1ns/1ps
module seg_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_we = 1'b0;
  logic [1:0]  seg_wsel = '0;
  logic [15:0] seg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic        ovr_valid = 1'b0;
  logic [1:0]  ovr_sel = '0;
  logic        direct = 1'b0;
  logic [15:0] disp_ofs = '0;
  logic [15:0] ind_ofs = '0;
  logic        pa_valid;
  logic [19:0] pa;
  logic [1:0]  pa_seg;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [15:0] segm [4];

  always #4 clk = ~clk;

  seg_addr_gen uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_sel(input logic [1:0] k, input logic ov, input logic [1:0] os);
    logic [1:0] s;
    case (k)
      2'd3: s = 2'd0;
      2'd2: s = 2'd2;
      2'd1: s = 2'd3;
      default: s = 2'd1;
    endcase
    if (ov && k != 2'd1) s = os;
    return s;
  endfunction

  function automatic logic [19:0] exp_pa(input logic [15:0] sg, input logic [15:0] o);
    return 20'(({4'd0, sg} << 4) + {4'd0, o});
  endfunction

  task automatic wr_seg(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk);
    seg_we = 1'b1; seg_wsel = s; seg_wdata = v;
    @(negedge clk);
    seg_we = 1'b0;
    segm[s] = v;
  endtask

  task automatic req(input string tag, input logic [1:0] k, input logic ov, input logic [1:0] os,
                     input logic dir, input logic [15:0] dsp, input logic [15:0] ind);
    logic [1:0] s;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; ovr_valid = ov; ovr_sel = os;
    direct = dir; disp_ofs = dsp; ind_ofs = ind;
    @(negedge clk);
    req_valid = 1'b0;
    s = exp_sel(k, ov, os);
    check({tag, " valid"}, 32'(pa_valid), 32'd1);
    check({tag, " pa"}, 32'(pa), 32'(exp_pa(segm[s], dir ? dsp : ind)));
    check({tag, " R11 seg"}, 32'(pa_seg), 32'(s));
  endtask

  initial begin
    #1500000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) segm[i] = '0;
    #1;
    check("R1 reset valid", 32'(pa_valid), 32'd0);
    check("R1 reset pa", 32'(pa), 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    req("R1 zero segs", 2'd0, 1'b0, 2'd0, 1'b1, 16'h1234, 16'h0);
    req("R1 zero segs fetch", 2'd3, 1'b0, 2'd0, 1'b0, 16'h0, 16'hBEEF);

    wr_seg(2'd0, 16'h1234);
    wr_seg(2'd1, 16'h2000);
    wr_seg(2'd2, 16'h3FF0);
    wr_seg(2'd3, 16'hA5C3);

    // R2 R3 R4 R5 R6 R7 sweep
    for (int k = 0; k < 4; k++)
      for (int ov = 0; ov < 2; ov++)
        for (int os = 0; os < 4; os++)
          for (int d = 0; d < 2; d++)
            for (int e = 0; e < 3; e++) begin
              logic [15:0] a, b;
              a = (e == 0) ? 16'h0000 : (e == 1) ? 16'h7A31 : 16'hFFFF;
              b = ~a ^ 16'h0F0F;
              req(k == 1 ? "R4 R2 sweep" : (ov != 0 ? "R6 R2 sweep" : "R3 R5 R7 R2 sweep"),
                  2'(k), 1'(ov), 2'(os), 1'(d), a, b);
            end

    // R10 wrap
    wr_seg(2'd1, 16'hFFFF);
    req("R10 wrap", 2'd0, 1'b0, 2'd0, 1'b1, 16'hFFFF, 16'h0);
    check("R10 wrap value", 32'(pa), 32'h0FFEF);
    req("R10 wrap min", 2'd0, 1'b0, 2'd0, 1'b0, 16'h0, 16'h0010);

    // R8 write in the same cycle as a request
    @(negedge clk);
    seg_we = 1'b1; seg_wsel = 2'd1; seg_wdata = 16'h0400;
    req_valid = 1'b1; req_kind = 2'd0; ovr_valid = 1'b0; direct = 1'b1; disp_ofs = 16'h0005;
    @(negedge clk);
    seg_we = 1'b0; req_valid = 1'b0;
    check("R8 old value used", 32'(pa), 32'(exp_pa(16'hFFFF, 16'h0005)));
    segm[1] = 16'h0400;
    req("R8 new value next", 2'd0, 1'b0, 2'd0, 1'b1, 16'h0005, 16'h0);
    check("R8 new value", 32'(pa), 32'h04005);

    // R9 idle holds
    @(negedge clk);
    check("R9 valid low", 32'(pa_valid), 32'd0);
    check("R9 pa held", 32'(pa), 32'h04005);
    check("R9 seg held", 32'(pa_seg), 32'd1);
    ind_ofs = 16'h1111; direct = 1'b0; req_kind = 2'd3;
    @(negedge clk);
    check("R9 pa held no req", 32'(pa), 32'h04005);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule